// File: doc/BRIEF.md
# Fourth-Order Cascaded Sigma-Delta Divider Controller

This block turns a 12-bit fractional frequency word into a stream of small signed integers that, added to an integer band offset, drive a multimodulus feedback divider once per reference clock. Four first-order accumulator stages are chained. Each stage adds the previous stage's residue from the same cycle and emits its overflow carry. The carries are shaped by registered first-difference chains and summed. Because the quantization error of the first three stages cancels exactly, only the last stage's error remains, high-pass shaped to fourth order.

A small controller adds a one-time seed to the first accumulator so that DC inputs cannot settle into a short limit cycle. It has two named states. Reset puts it in `ST_PLANT`, where it injects a single least-significant one into stage one. On the next clock edge it always moves to `ST_RUN`, and it stays in `ST_RUN` until the next reset. A final register adds the unsigned band offset to the signed shaped sum and presents the divide-ratio word.

Top module: `mash4_sdm`

## Requirements
- R1: While reset is held low, `div_ratio` reads 0.
- R2: In the first clock cycle after reset release, and in no other cycle, the first accumulator receives an extra +1. With `frac_word` = 4095 from release, the first shaped value is therefore +1.
- R3: Each accumulator is 12 bits wide and wraps modulo 4096. Its carry is 1 when residue plus addend (plus seed) reaches 4096. Stage k+1 adds stage k's new residue from the same cycle.
- R4: The shaped value is y = c1 + Δc2 + Δ²c3 + Δ³c4. Here ck is stage k's carry and Δ is the first difference against the previous cycle's value, taken as 0 before reset release. The match is bit exact.
- R5: The shaped value y always lies in −7..+8.
- R6: The carries captured at clock edge m first appear in `div_ratio` after edge m+5. The band offset is sampled only at the final register, so it appears after the edge at which it is presented.
- R7: `div_ratio` = (`band_offset` + y) mod 128, with the offset taken as an unsigned number and y as a two's-complement number.
- R8: For a constant input x, the sum of (`div_ratio` − offset) over 65536 consecutive outputs equals 16·x within ±4.
- R9: A reset asserted mid-operation clears all accumulators, carries and difference history, and re-applies the seed on release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frac_word | input | 12 | Unsigned fractional frequency word, LSB = f_ref/4096 |
| band_offset | input | 6 | Unsigned integer band offset |
| div_ratio | output | 7 | Divide-ratio word: offset plus shaped sum |

## Verification
The embedded assertions check four properties on every cycle. The seed pulse is a single cycle and is followed by a permanent run state. Each accumulator conserves value, so residue plus carry weight equals the previous residue plus addend. Each difference chain stays within its order's bound, and the shaped sum stays within −7..+8. The output minus the previous cycle's offset also stays in that window. Only the bench's scenarios can show bit-exact cancellation against an independent model, the exact five-cycle alignment, the seed's visible effect after release and after a mid-run reset, and the long-run average equalling the fractional input.

// File: rtl/mash_pkg.sv
package mash_pkg;

    // Seed controller states
    typedef enum logic {
        ST_PLANT = 1'b0,
        ST_RUN   = 1'b1
    } seed_state_t;

    // Magnitude bound of a d-th order first difference of a 0/1 carry
    function automatic int diff_bound(input int order_d);
        if (order_d <= 0) begin
            return 1;
        end
        return 1 << (order_d - 1);
    endfunction

endpackage

// File: rtl/mash_seed_ctrl.sv
module mash_seed_ctrl
    import mash_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic seed
);

    seed_state_t state_q;
    seed_state_t state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PLANT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PLANT: state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        seed = 1'b0;
        unique case (state_q)
            ST_PLANT: seed = 1'b1;
            ST_RUN:   seed = 1'b0;
        endcase
    end

    AST_SEED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        seed |=> !seed); // R2
    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (state_q == ST_RUN)); // R2

endmodule

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
    parameter int ACC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] addend,
    input  logic             cin,
    output logic [ACC_W-1:0] residue_next,
    output logic             carry_q
);

    logic [ACC_W-1:0] residue_q;
    logic [ACC_W:0]   total;

    assign total        = {1'b0, residue_q} + {1'b0, addend} + {{ACC_W{1'b0}}, cin};
    assign residue_next = total[ACC_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            residue_q <= '0;
            carry_q   <= 1'b0;
        end else begin
            residue_q <= total[ACC_W-1:0];
            carry_q   <= total[ACC_W];
        end
    end

    // Value is conserved: new residue plus carry weight equals old residue plus inputs
    AST_ACC_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ({1'b0, residue_q} + {carry_q, {ACC_W{1'b0}}}
                          == {1'b0, $past(residue_q)} + {1'b0, $past(addend)}
                             + {{ACC_W{1'b0}}, $past(cin)})); // R3

endmodule

// File: rtl/mash_diff_chain.sv
module mash_diff_chain
    import mash_pkg::*;
#(
    parameter int Y_W   = 5,
    parameter int DEPTH = 3,
    parameter int DIFFS = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                carry,
    output logic signed [Y_W-1:0] shaped
);

    localparam int BOUND = diff_bound(DIFFS);

    for (genvar j = 0; j < DEPTH; j++) begin : g_lvl
        logic signed [Y_W-1:0] src;
        logic signed [Y_W-1:0] prev_q;
        logic signed [Y_W-1:0] val_q;

        if (j == 0) begin : g_in
            assign src = {{(Y_W-1){1'b0}}, carry};
        end else begin : g_link
            assign src = g_lvl[j-1].val_q;
        end

        if (j < DIFFS) begin : g_diff
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prev_q <= '0;
                    val_q  <= '0;
                end else begin
                    prev_q <= src;
                    val_q  <= src - prev_q;
                end
            end
        end else begin : g_delay
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prev_q <= '0;
                    val_q  <= '0;
                end else begin
                    prev_q <= src;
                    val_q  <= src;
                end
            end
        end
    end

    assign shaped = g_lvl[DEPTH-1].val_q;

    AST_SHAPED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (shaped <= BOUND) && (shaped >= -BOUND)); // R4

endmodule

// File: rtl/mash4_sdm.sv
module mash4_sdm #(
    parameter  int ACC_W = 12,
    parameter  int ORDER = 4,
    parameter  int OFS_W = 6,
    localparam int DIV_W = OFS_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] frac_word,
    input  logic [OFS_W-1:0] band_offset,
    output logic [DIV_W-1:0] div_ratio
);

    localparam int Y_W   = ORDER + 1;
    localparam int DEPTH = ORDER - 1;
    localparam int Y_MAX = 1 << (ORDER - 1);
    localparam int Y_MIN = 1 - Y_MAX;

    logic                  seed;
    logic [ACC_W-1:0]      residue_arr [ORDER];
    logic                  carry_arr   [ORDER];
    logic signed [Y_W-1:0] shaped_arr  [ORDER];
    logic signed [Y_W-1:0] y_sum;
    logic signed [Y_W-1:0] y_q;
    logic [DIV_W-1:0]      div_q;

    mash_seed_ctrl u_seed (
        .clk   (clk),
        .rst_n (rst_n),
        .seed  (seed)
    );

    for (genvar k = 0; k < ORDER; k++) begin : g_stg
        logic [ACC_W-1:0] addend;
        logic             cin;

        if (k == 0) begin : g_first
            assign addend = frac_word;
            assign cin    = seed;
        end else begin : g_next
            assign addend = residue_arr[k-1];
            assign cin    = 1'b0;
        end

        mash_acc_stage #(.ACC_W(ACC_W)) u_acc (
            .clk          (clk),
            .rst_n        (rst_n),
            .addend       (addend),
            .cin          (cin),
            .residue_next (residue_arr[k]),
            .carry_q      (carry_arr[k])
        );

        mash_diff_chain #(.Y_W(Y_W), .DEPTH(DEPTH), .DIFFS(k)) u_chain (
            .clk    (clk),
            .rst_n  (rst_n),
            .carry  (carry_arr[k]),
            .shaped (shaped_arr[k])
        );
    end

    // Noise-cancellation sum
    always_comb begin
        y_sum = '0;
        for (int k = 0; k < ORDER; k++) begin
            y_sum = y_sum + shaped_arr[k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_q <= '0;
        end else begin
            y_q <= y_sum;
        end
    end

    // Band offset adder and divider translation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= DIV_W'(band_offset) + DIV_W'(y_q);
        end
    end

    assign div_ratio = div_q;

    AST_Y_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (y_q >= Y_MIN) && (y_q <= Y_MAX)); // R5
    AST_DIV_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
            (($signed(DIV_W'(div_ratio - DIV_W'($past(band_offset)))) >= Y_MIN) &&
             ($signed(DIV_W'(div_ratio - DIV_W'($past(band_offset)))) <= Y_MAX))); // R7

endmodule

// File: tb/mash4_sdm_tb.sv
module mash4_sdm_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] frac = '0;
    logic [5:0]  ofs = '0;
    logic [6:0]  div;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // Independent model state
    int s0, s1, s2, s3;
    int c2p, c3p, c3pp, c4p, c4pp, c4ppp;
    int ytr [8];
    int m;

    always #4 clk = ~clk;

    mash4_sdm u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frac_word   (frac),
        .band_offset (ofs),
        .div_ratio   (div)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, m);
        end
    endtask

    task automatic model_clear();
        s0 = 0; s1 = 0; s2 = 0; s3 = 0;
        c2p = 0; c3p = 0; c3pp = 0; c4p = 0; c4pp = 0; c4ppp = 0;
        for (int i = 0; i < 8; i++) ytr[i] = 0;
        m = 0;
    endtask

    // One edge of the cascade: R3 accumulation, R4 combination
    task automatic model_edge(input int x, input int sd, output int y);
        int t, c1, c2, c3, c4;
        t = s0 + x + sd;  c1 = t >> 12; s0 = t & 4095;
        t = s1 + s0;      c2 = t >> 12; s1 = t & 4095;
        t = s2 + s1;      c3 = t >> 12; s2 = t & 4095;
        t = s3 + s2;      c4 = t >> 12; s3 = t & 4095;
        y = c1 + (c2 - c2p) + (c3 - 2*c3p + c3pp) + (c4 - 3*c4p + 3*c4pp - c4ppp);
        c2p = c2;
        c3pp = c3p; c3p = c3;
        c4ppp = c4pp; c4pp = c4p; c4p = c4;
    endtask

    // Drive for next edge, then check after it (R4, R6, R7)
    task automatic tick(input int xv, input int ov);
        int y, e;
        frac = 12'(xv);
        ofs  = 6'(ov);
        m++;
        model_edge(xv, (m == 1) ? 1 : 0, y);
        ytr[m % 8] = y;
        @(negedge clk);
        e = ov + ((m >= 6) ? ytr[(m - 5) % 8] : 0);
        chk(int'(div) == (e & 127), "R4/R6/R7 model", int'(div), e & 127);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        frac = '0;
        ofs = 6'd17;
        repeat (3) @(negedge clk);
        chk(div == 7'd0, "R1 reset value", int'(div), 0);
        model_clear();
        rst_n = 1'b1;
    endtask

    initial begin
        int d;
        longint acc;
        void'($urandom(32'h1DEA));
        @(negedge clk);
        do_reset();

        // R2 seed with full-scale input, R6 latency
        for (int i = 1; i <= 6; i++) begin
            tick(4095, 30);
            if (i == 5) chk(div == 7'd30, "R6 latency", int'(div), 30);
            if (i == 6) chk(div == 7'd31, "R2 seed", int'(div), 31);
        end
        for (int i = 0; i < 500; i++) tick(4095, 30);
        for (int i = 0; i < 500; i++) tick(1, 12);

        // R5 random inputs and offsets
        for (int i = 0; i < 4000; i++) begin
            int ov;
            ov = 8 + int'($urandom_range(0, 47));
            tick(int'($urandom_range(0, 4095)), ov);
            d = int'(div) - ov;
            if (m >= 6) chk(d >= -7 && d <= 8, "R5 range", d, 0);
        end

        // R9 mid-run reset, then seed and model again
        do_reset();
        for (int i = 1; i <= 6; i++) begin
            tick(4095, 40);
            if (i == 6) chk(div == 7'd41, "R9 restart seed", int'(div), 41);
        end
        for (int i = 0; i < 300; i++) tick(int'($urandom_range(0, 4095)), 25);

        // R8 long-run average with DC input
        do_reset();
        acc = 0;
        for (int i = 0; i < 65541; i++) begin
            tick(1234, 32);
            if (m >= 6) acc += longint'(int'(div) - 32);
        end
        chk((acc >= 19744 - 4) && (acc <= 19744 + 4), "R8 average", int'(acc), 19744);

        // Edge cases of the input word
        do_reset();
        for (int i = 0; i < 400; i++) tick(0, 9);
        for (int i = 0; i < 400; i++) tick(2048, 50);

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #1600000;
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule